// File: doc/BRIEF.md
# Grid Interconnect Trip Controller

This block decides when a grid-tied generator must stop energizing the utility connection and when it may connect again. It takes a measured RMS voltage, a measured frequency, a phase-lock flag, a feedback contact from the interconnect relay, a plant-wide trip request and a one-millisecond tick. It drives the relay close command, a one-cycle trip interrupt, a latched numeric fault code and an OPEN/CLOSED status bit.

Voltage arrives as an unsigned fixed-point ratio to nominal with `VFRAC` fractional bits, so 4096 is 1.0 with the default 12 bits. Frequency arrives in millihertz. A trip takes effect at the first clock edge that samples the abnormal input. After a trip the relay stays open until the inputs have been free of every trip condition for a long, tick-counted hold-off window. Any new condition during that window starts the window again. While the relay is open, a supervision timer confirms that the feedback contact has actually opened.

Top module: `grid_trip_ctrl`

## Requirements
- R1: A voltage ratio above `V_OV_PCT` percent of nominal (default 110 %, volt_ratio*100 > 110*4096, so 4506 trips and 4505 does not) trips the link. So does a ratio below `V_UV_PCT` percent (default 88 %, so 3604 trips and 3605 does not). Either case is recorded as fault code 103.
- R2: A frequency above `F_OV_MHZ` (60500 mHz) or below `F_UV_MHZ` (59300 mHz) trips the link and records code 104. Exactly 60500 and exactly 59300 do not trip.
- R3: pll_lock low trips the link and records code 201.
- R4: global_trip high trips the link and records code 900, whatever the measurements show.
- R5: When several conditions start in the same cycle, the recorded code follows the priority 900 over 201 over 104 over 103.
- R6: A trip condition sampled at a clock edge while CLOSED drops relay_close and raises st_open (1 = OPEN, 0 = CLOSED) at that same edge.
- R7: trip_irq is high for exactly one cycle after each CLOSED-to-OPEN transition, and at no other time.
- R8: Trip conditions that arrive while OPEN do not pulse trip_irq and do not change the state or the recorded code. The one exception is the relay mismatch of R11.
- R9: The first code recorded after a trip is held until the relay recloses. fault_code reads 0 whenever the link is CLOSED.
- R10: Reclosing happens only after `HOLD_MS` consecutive tick_1ms pulses that all carry no trip condition. Any trip condition clears the count. Cycles without a tick pulse do not advance it.
- R11: If relay_fb_closed still reads 1 after `RELAY_MS` tick pulses in the OPEN state, fault_code becomes 505, overriding the held code. The mismatch counts as a trip condition for as long as it lasts.
- R12: Reset leaves the block OPEN with fault_code 0 and trip_irq 0. The full hold-off of R10 must then elapse before the first close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| volt_ratio | input | VW | RMS voltage as a fixed-point ratio to nominal |
| freq_mhz | input | FW | Measured frequency in millihertz |
| pll_lock | input | 1 | Phase-lock indication, 1 = locked |
| relay_fb_closed | input | 1 | Relay feedback contact, 1 = contacts closed |
| global_trip | input | 1 | Plant-level trip request |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| relay_close | output | 1 | Relay close command |
| trip_irq | output | 1 | One-cycle trip interrupt |
| fault_code | output | 10 | Latched fault code, 0 = none |
| st_open | output | 1 | Link status, 1 = OPEN |

## Verification
The expiry of the hold-off window and a fresh trip condition can fall in the same cycle. The correct outcome is that the link stays OPEN, no interrupt fires and the count restarts from zero. The bench provokes this by letting exactly `HOLD_MS` quiet ticks pass and then raising the global trip in the very next cycle. It then confirms that the link stays open for a further full window and closes only one edge after that window ends. Several trip sources starting in the same cycle are also checked, to confirm the recorded code follows the stated priority.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
    localparam int CODE_W = 10;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_NONE   = 10'd0;
    localparam code_t CODE_VOLT   = 10'd103;
    localparam code_t CODE_FREQ   = 10'd104;
    localparam code_t CODE_PLL    = 10'd201;
    localparam code_t CODE_RELAY  = 10'd505;
    localparam code_t CODE_GLOBAL = 10'd900;

    typedef enum logic {
        ST_CLOSED = 1'b0,
        ST_OPEN   = 1'b1
    } link_st_e;

    typedef struct packed {
        logic relay;
        logic glob;
        logic pll;
        logic freq;
        logic volt;
    } trip_src_t;
endpackage

// File: rtl/gtc_window.sv
// Scaled window comparator: flags a value strictly above or below its limits.
module gtc_window #(
    parameter int unsigned W      = 16,
    parameter int unsigned SCALE  = 1,
    parameter int unsigned LO_LIM = 0,
    parameter int unsigned HI_LIM = 1
) (
    input  logic [W-1:0] val,
    output logic         above,
    output logic         below
);
    localparam int unsigned PW = W + $clog2(SCALE + 1);

    logic [PW-1:0] scaled;

    always_comb begin
        scaled = PW'(val) * PW'(SCALE);
        above  = scaled > PW'(HI_LIM);
        below  = scaled < PW'(LO_LIM);
    end
endmodule

// File: rtl/gtc_timer.sv
// Tick counter that saturates at LIMIT; done marks a full window.
module gtc_timer #(
    parameter int unsigned LIMIT = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != LIM)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == LIM);
endmodule

// File: rtl/gtc_fault_enc.sv
// Priority encoder from active trip sources to a fault code.
module gtc_fault_enc
    import gtc_pkg::*;
(
    input  trip_src_t src,
    output code_t     code,
    output logic      any
);
    always_comb begin
        any = |src;
        if (src.relay) begin
            code = CODE_RELAY;
        end else if (src.glob) begin
            code = CODE_GLOBAL;
        end else if (src.pll) begin
            code = CODE_PLL;
        end else if (src.freq) begin
            code = CODE_FREQ;
        end else if (src.volt) begin
            code = CODE_VOLT;
        end else begin
            code = CODE_NONE;
        end
    end
endmodule

// File: rtl/grid_trip_ctrl.sv
module grid_trip_ctrl
    import gtc_pkg::*;
#(
    parameter int unsigned VW       = 16,
    parameter int unsigned VFRAC    = 12,
    parameter int unsigned FW       = 17,
    parameter int unsigned V_OV_PCT = 110,
    parameter int unsigned V_UV_PCT = 88,
    parameter int unsigned F_OV_MHZ = 60500,
    parameter int unsigned F_UV_MHZ = 59300,
    parameter int unsigned HOLD_MS  = 300000,
    parameter int unsigned RELAY_MS = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VW-1:0]     volt_ratio,
    input  logic [FW-1:0]     freq_mhz,
    input  logic              pll_lock,
    input  logic              relay_fb_closed,
    input  logic              global_trip,
    input  logic              tick_1ms,
    output logic              relay_close,
    output logic              trip_irq,
    output logic [CODE_W-1:0] fault_code,
    output logic              st_open
);
    localparam int unsigned V_HI_LIM = V_OV_PCT << VFRAC;
    localparam int unsigned V_LO_LIM = V_UV_PCT << VFRAC;

    typedef struct packed {
        link_st_e st;
        code_t    code;
        logic     irq;
    } ctl_t;

    ctl_t      c_d, c_q;
    trip_src_t src;
    code_t     enc_code;
    logic      any_trip;
    logic      v_hi, v_lo, f_hi, f_lo;
    logic      hold_done, rly_done;
    logic      hold_clr, rly_clr;

    gtc_window #(
        .W(VW), .SCALE(100), .LO_LIM(V_LO_LIM), .HI_LIM(V_HI_LIM)
    ) u_volt_win (
        .val(volt_ratio), .above(v_hi), .below(v_lo)
    );

    gtc_window #(
        .W(FW), .SCALE(1), .LO_LIM(F_UV_MHZ), .HI_LIM(F_OV_MHZ)
    ) u_freq_win (
        .val(freq_mhz), .above(f_hi), .below(f_lo)
    );

    always_comb begin
        src.volt  = v_hi | v_lo;
        src.freq  = f_hi | f_lo;
        src.pll   = ~pll_lock;
        src.glob  = global_trip;
        src.relay = (c_q.st == ST_OPEN) && rly_done && relay_fb_closed;
    end

    gtc_fault_enc u_enc (
        .src(src), .code(enc_code), .any(any_trip)
    );

    assign hold_clr = (c_q.st == ST_CLOSED) || any_trip;
    assign rly_clr  = (c_q.st == ST_CLOSED);

    gtc_timer #(.LIMIT(HOLD_MS)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr(hold_clr), .tick(tick_1ms), .done(hold_done)
    );

    gtc_timer #(.LIMIT(RELAY_MS)) u_rly (
        .clk(clk), .rst_n(rst_n), .clr(rly_clr), .tick(tick_1ms), .done(rly_done)
    );

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        unique case (c_q.st)
            ST_CLOSED: begin
                if (any_trip) begin
                    c_d.st   = ST_OPEN;
                    c_d.irq  = 1'b1;
                    c_d.code = enc_code;
                end
            end
            ST_OPEN: begin
                if (src.relay) begin
                    c_d.code = CODE_RELAY;
                end else if (any_trip) begin
                    if (c_q.code == CODE_NONE) begin
                        c_d.code = enc_code;
                    end
                end else if (hold_done) begin
                    c_d.st   = ST_CLOSED;
                    c_d.code = CODE_NONE;
                end
            end
            default: c_d = c_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_OPEN, code: CODE_NONE, irq: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign relay_close = (c_q.st == ST_CLOSED);
    assign st_open     = (c_q.st == ST_OPEN);
    assign trip_irq    = c_q.irq;
    assign fault_code  = c_q.code;
endmodule

// File: rtl/gtc_checker.sv
module gtc_checker
    import gtc_pkg::*;
#(
    parameter int unsigned HOLD_MS = 300000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pll_lock,
    input logic              global_trip,
    input logic              tick_1ms,
    input logic              relay_close,
    input logic              trip_irq,
    input logic [CODE_W-1:0] fault_code,
    input logic              st_open
);
    // ticks seen at edges since the relay last became open
    logic [31:0] open_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_ticks <= '0;
        end else if (relay_close) begin
            open_ticks <= '0;
        end else if (tick_1ms && (open_ticks != 32'hFFFF_FFFF)) begin
            open_ticks <= open_ticks + 32'd1;
        end
    end

    p_irq_marks_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trip_irq |-> (st_open && $past(relay_close)));

    p_no_irq_while_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_open && $past(st_open)) |-> !trip_irq);

    p_global_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        global_trip |=> !relay_close);

    p_pll_loss_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_lock |=> st_open);

    p_code_zero_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        relay_close |-> (fault_code == CODE_NONE));

    p_code_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_open && $past(st_open) && ($past(fault_code) != CODE_NONE)
         && (fault_code != CODE_RELAY)) |-> $stable(fault_code));

    p_holdoff_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relay_close) |-> (open_ticks >= HOLD_MS));

    p_reclose_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relay_close) |-> $past(pll_lock && !global_trip));
endmodule

bind grid_trip_ctrl gtc_checker #(.HOLD_MS(HOLD_MS)) u_gtc_chk (
    .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .global_trip(global_trip),
    .tick_1ms(tick_1ms), .relay_close(relay_close), .trip_irq(trip_irq),
    .fault_code(fault_code), .st_open(st_open)
);

// File: tb/test_grid_trip_ctrl.sv
module test_grid_trip_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 20;
    localparam int RLY  = 5;
    localparam logic [15:0] V_NOM = 16'd4096;
    localparam logic [16:0] F_NOM = 17'd60000;

    typedef struct packed {
        logic [15:0] v;
        logic [16:0] f;
        logic        pll;
        logic        glob;
        logic        trip;
        logic [9:0]  code;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'd4506, 17'd60000, 1'b1, 1'b0, 1'b1, 10'd103, 4'd1},
        '{16'd4505, 17'd60000, 1'b1, 1'b0, 1'b0, 10'd0,   4'd1},
        '{16'd3604, 17'd60000, 1'b1, 1'b0, 1'b1, 10'd103, 4'd1},
        '{16'd3605, 17'd60000, 1'b1, 1'b0, 1'b0, 10'd0,   4'd1},
        '{16'd4096, 17'd60501, 1'b1, 1'b0, 1'b1, 10'd104, 4'd2},
        '{16'd4096, 17'd60500, 1'b1, 1'b0, 1'b0, 10'd0,   4'd2},
        '{16'd4096, 17'd59299, 1'b1, 1'b0, 1'b1, 10'd104, 4'd2},
        '{16'd4096, 17'd59300, 1'b1, 1'b0, 1'b0, 10'd0,   4'd2},
        '{16'd4096, 17'd60000, 1'b0, 1'b0, 1'b1, 10'd201, 4'd3},
        '{16'd4096, 17'd60000, 1'b1, 1'b1, 1'b1, 10'd900, 4'd4},
        '{16'd4096, 17'd62000, 1'b0, 1'b1, 1'b1, 10'd900, 4'd5},
        '{16'd5000, 17'd60000, 1'b0, 1'b0, 1'b1, 10'd201, 4'd5},
        '{16'd3000, 17'd58000, 1'b1, 1'b0, 1'b1, 10'd104, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] volt_ratio;
    logic [16:0] freq_mhz;
    logic        pll_lock;
    logic        global_trip;
    logic        tick_1ms;
    logic        fb_stuck;
    logic        relay_fb_closed;
    logic        relay_close;
    logic        trip_irq;
    logic [9:0]  fault_code;
    logic        st_open;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign relay_fb_closed = relay_close | fb_stuck;

    grid_trip_ctrl #(.HOLD_MS(HOLD), .RELAY_MS(RLY)) i_grid_trip_ctrl (
        .clk(clk), .rst_n(rst_n), .volt_ratio(volt_ratio), .freq_mhz(freq_mhz),
        .pll_lock(pll_lock), .relay_fb_closed(relay_fb_closed),
        .global_trip(global_trip), .tick_1ms(tick_1ms),
        .relay_close(relay_close), .trip_irq(trip_irq),
        .fault_code(fault_code), .st_open(st_open)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic nominal(input logic tk);
        volt_ratio  = V_NOM;
        freq_mhz    = F_NOM;
        pll_lock    = 1'b1;
        global_trip = 1'b0;
        tick_1ms    = tk;
    endtask

    task automatic go_closed();
        int guard;
        nominal(1'b1);
        guard = 0;
        while (!relay_close && guard < 8 * HOLD) begin
            adv(1);
            guard++;
        end
        check("R10 reach closed", int'(relay_close), 1);
    endtask

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        fb_stuck = 1'b0;
        nominal(1'b1);
        adv(3);
        // R12: reset state
        check("R12 st_open in reset", int'(st_open), 1);
        check("R12 relay_close in reset", int'(relay_close), 0);
        check("R12 fault_code in reset", int'(fault_code), 0);
        check("R12 trip_irq in reset", int'(trip_irq), 0);
        rst_n = 1'b1;
        adv(HOLD);
        check("R12 still open at hold end", int'(st_open), 1);
        adv(1);
        check("R12 first close", int'(relay_close), 1);
        check("R12 irq none", int'(trip_irq), 0);

        // table: R1..R5, with R6 latency and R7 pulse
        for (int i = 0; i < NV; i++) begin
            go_closed();
            volt_ratio  = VECS[i].v;
            freq_mhz    = VECS[i].f;
            pll_lock    = VECS[i].pll;
            global_trip = VECS[i].glob;
            tick_1ms    = 1'b0;
            adv(1);
            check({tag(VECS[i].req), " R6 st_open"}, int'(st_open), int'(VECS[i].trip));
            check({tag(VECS[i].req), " R6 relay_close"}, int'(relay_close), int'(!VECS[i].trip));
            check({tag(VECS[i].req), " code"}, int'(fault_code), int'(VECS[i].code));
            check({tag(VECS[i].req), " R7 irq"}, int'(trip_irq), int'(VECS[i].trip));
            nominal(1'b0);
            adv(1);
            check("R7 irq single cycle", int'(trip_irq), 0);
        end

        // R8 / R9: later conditions while open change nothing
        go_closed();
        freq_mhz = 17'd61000;
        tick_1ms = 1'b0;
        adv(1);
        check("R9 first code", int'(fault_code), 104);
        freq_mhz    = F_NOM;
        global_trip = 1'b1;
        adv(1);
        check("R8 no irq on repeat", int'(trip_irq), 0);
        check("R8 code kept on global", int'(fault_code), 104);
        global_trip = 1'b0;
        pll_lock    = 1'b0;
        adv(1);
        check("R8 code kept on pll", int'(fault_code), 104);
        check("R8 still open", int'(st_open), 1);

        // R10: restart of hold-off
        nominal(1'b1);
        adv(HOLD - 3);
        check("R10 open mid window", int'(st_open), 1);
        volt_ratio = 16'd5000;
        adv(1);
        nominal(1'b1);
        adv(HOLD);
        check("R10 open after restart window", int'(st_open), 1);
        check("R9 code held while open", int'(fault_code), 104);
        adv(1);
        check("R10 close after restart", int'(relay_close), 1);
        check("R9 code cleared on close", int'(fault_code), 0);

        // R10: cycles without tick do not count
        pll_lock = 1'b0;
        tick_1ms = 1'b0;
        adv(1);
        nominal(1'b0);
        adv(3 * HOLD);
        check("R10 no tick keeps open", int'(st_open), 1);
        tick_1ms = 1'b1;
        adv(HOLD);
        check("R10 open before full ticks", int'(st_open), 1);
        adv(1);
        check("R10 close after ticks", int'(relay_close), 1);

        // R10: new trip in the same cycle as expiry
        global_trip = 1'b1;
        adv(1);
        nominal(1'b1);
        adv(HOLD);
        check("R10 open at expiry", int'(st_open), 1);
        global_trip = 1'b1;
        adv(1);
        check("R10 expiry collision stays open", int'(st_open), 1);
        check("R8 collision no irq", int'(trip_irq), 0);
        nominal(1'b1);
        adv(HOLD);
        check("R10 open after collision window", int'(st_open), 1);
        adv(1);
        check("R10 close after collision", int'(relay_close), 1);

        // R11: relay feedback mismatch
        fb_stuck   = 1'b1;
        volt_ratio = 16'd3000;
        adv(1);
        check("R11 trip code", int'(fault_code), 103);
        nominal(1'b1);
        adv(RLY);
        check("R11 code before window", int'(fault_code), 103);
        adv(1);
        check("R11 mismatch code", int'(fault_code), 505);
        adv(2 * HOLD);
        check("R11 held open", int'(st_open), 1);
        check("R11 code kept", int'(fault_code), 505);
        fb_stuck = 1'b0;
        adv(HOLD);
        check("R11 open until window", int'(st_open), 1);
        adv(1);
        check("R11 close after release", int'(relay_close), 1);
        check("R11 code cleared", int'(fault_code), 0);

        summary();
        $finish;
    end
endmodule